// File: doc/BRIEF.md
# USB Host Functional State Controller

This block keeps the two-bit functional state of a USB host controller together with the enables for the control and bulk transfer lists. Software changes the state and the enables through a single-cycle register write port. Hardware makes one state change on its own: while the controller is suspended and a downstream resume signal is seen, the state moves to resume and a one-cycle event pulse is raised so that an interrupt can be generated.

The list enables written by software are held in staging registers. Only at a frame boundary (`frame_start`) are they copied into the active enables that list processing reads. A write in the middle of a frame therefore never changes the frame already running. A hardware reset leaves the controller in the reset state. A software reset leaves it in suspend.

The state machine has four states: RESET (00), RESUME (01), OPER (10) and SUSPEND (11). Its transitions are named as follows:
- SW_RESET: any state goes to SUSPEND.
- SW_WRITE: any state goes to the state written by software.
- AUTO_RESUME: SUSPEND goes to RESUME when a resume signal is detected.
- HOLD: the state stays as it is in every other case.

Top module: `usb_hc_state_ctrl`

## Requirements
- R1: `hcfs` uses the encoding 00 = RESET, 01 = RESUME, 10 = OPER, 11 = SUSPEND.
- R2: While `rst_n` is low, `hcfs` is 00, and `ble_active`, `cle_active`, `resume_event` and both staged enables are 0.
- R3: When `wr_en` is high, `hcfs` takes `wdata[1:0]` on the next cycle. The staged control enable takes `wdata[2]` and the staged bulk enable takes `wdata[3]`. `wdata[7:4]` are ignored.
- R4: When `sw_reset` is high, `hcfs` becomes 11 on the next cycle, and both the staged and the active enables clear. This overrides `wr_en`, `frame_start` and `resume_detect`.
- R5: `resume_detect` has no effect while `hcfs` is not 11.
- R6: When `hcfs` is 11 and `resume_detect` is high, with neither `wr_en` nor `sw_reset`, `hcfs` becomes 01 on the next cycle.
- R7: On `frame_start`, `ble_active` and `cle_active` load the staged enables as they stood before any write in that same cycle.
- R8: Without `frame_start` or `sw_reset`, `ble_active` and `cle_active` do not change, whatever is written.
- R9: A software write in the same cycle as a resume detection in SUSPEND wins: `hcfs` takes the written value.
- R10: `resume_event` is high for exactly the one cycle in which `hcfs` first shows 01 after an AUTO_RESUME, and is low after every other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data: [1:0] state, [2] control enable, [3] bulk enable |
| frame_start | input | 1 | Frame boundary pulse |
| resume_detect | input | 1 | Resume signal seen on the downstream port |
| sw_reset | input | 1 | Software reset pulse |
| hcfs | output | 2 | Current functional state |
| ble_active | output | 1 | Bulk list enable in force for this frame |
| cle_active | output | 1 | Control list enable in force for this frame |
| resume_event | output | 1 | One-cycle pulse on an autonomous resume |

## Verification
The bench targets the cycles where several inputs collide:
- A write together with a frame boundary. A design that latched the new value would change list processing in the middle of the frame.
- A write together with a resume detection. A design that let hardware win would lose the software state and raise a spurious event.
- A software reset together with everything else. A design that got this wrong would leave the controller in RESET rather than SUSPEND, or keep stale enables.

It also pulses `resume_detect` in RESET, RESUME and OPER, where a design that reacts would leave the software-written state.

// File: rtl/hc_state_pkg.sv
package hc_state_pkg;
    localparam int STATE_W  = 2;
    localparam int N_LISTS  = 2;
    localparam int DATA_W   = 8;
    localparam int ST_LSB   = 0;
    localparam int CTRL_BIT = 2;
    localparam int BULK_BIT = 3;
    localparam int LIST_CTRL = 0;
    localparam int LIST_BULK = 1;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET   = 2'b00,
        ST_RESUME  = 2'b01,
        ST_OPER    = 2'b10,
        ST_SUSPEND = 2'b11
    } hc_state_e;
endpackage

// File: rtl/hcfs_fsm.sv
module hcfs_fsm
    import hc_state_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_reset,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_state,
    input  logic               resume_detect,
    output hc_state_e          state,
    output logic               resume_event
);
    hc_state_e state_q, state_d;
    logic      event_q, event_d;

    // next-state selection: SW_RESET > SW_WRITE > AUTO_RESUME > HOLD
    always_comb begin
        state_d = state_q;
        event_d = 1'b0;
        if (sw_reset) begin
            state_d = ST_SUSPEND;
        end else if (wr_en) begin
            state_d = hc_state_e'(wr_state);
        end else begin
            unique case (state_q)
                ST_SUSPEND: begin
                    if (resume_detect) begin
                        state_d = ST_RESUME;
                        event_d = 1'b1;
                    end
                end
                ST_RESET, ST_RESUME, ST_OPER: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            event_q <= 1'b0;
        end else begin
            state_q <= state_d;
            event_q <= event_d;
        end
    end

    // outputs
    always_comb begin
        state        = state_q;
        resume_event = event_q;
    end
endmodule

// File: rtl/list_enable_stage.sv
module list_enable_stage #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_reset,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic         frame_start,
    output logic [N-1:0] active
);
    logic [N-1:0] staged_q;
    logic [N-1:0] active_q;

    for (genvar i = 0; i < N; i++) begin : g_list
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                staged_q[i] <= 1'b0;
                active_q[i] <= 1'b0;
            end else if (sw_reset) begin
                staged_q[i] <= 1'b0;
                active_q[i] <= 1'b0;
            end else begin
                if (frame_start) active_q[i] <= staged_q[i];
                if (wr_en)       staged_q[i] <= wr_bits[i];
            end
        end
    end

    assign active = active_q;
endmodule

// File: rtl/usb_hc_state_ctrl.sv
module usb_hc_state_ctrl
    import hc_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_start,
    input  logic              resume_detect,
    input  logic              sw_reset,
    output logic [1:0]        hcfs,
    output logic              ble_active,
    output logic              cle_active,
    output logic              resume_event
);
    hc_state_e    state;
    logic [N_LISTS-1:0] wr_bits;
    logic [N_LISTS-1:0] active;
    logic         wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:BULK_BIT+1];

    assign wr_bits[LIST_CTRL] = wdata[CTRL_BIT];
    assign wr_bits[LIST_BULK] = wdata[BULK_BIT];

    hcfs_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_reset      (sw_reset),
        .wr_en         (wr_en),
        .wr_state      (wdata[ST_LSB +: STATE_W]),
        .resume_detect (resume_detect),
        .state         (state),
        .resume_event  (resume_event)
    );

    list_enable_stage #(.N(N_LISTS)) u_lists (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .wr_en       (wr_en),
        .wr_bits     (wr_bits),
        .frame_start (frame_start),
        .active      (active)
    );

    assign hcfs       = state;
    assign cle_active = active[LIST_CTRL];
    assign ble_active = active[LIST_BULK];
endmodule

// File: rtl/hc_state_checker.sv
module hc_state_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic       frame_start,
    input logic       resume_detect,
    input logic       sw_reset,
    input logic [1:0] hcfs,
    input logic       ble_active,
    input logic       cle_active,
    input logic       resume_event
);
    a_r4_sw_reset_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (hcfs == 2'b11) && !ble_active && !cle_active && !resume_event);

    a_r5_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sw_reset && hcfs != 2'b11) |=> $stable(hcfs) && !resume_event);

    a_r6_auto_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (hcfs == 2'b11 && resume_detect && !wr_en && !sw_reset) |=> (hcfs == 2'b01));

    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !sw_reset) |=> $stable({ble_active, cle_active}));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sw_reset) |=> (hcfs == $past(wdata[1:0])) && !resume_event);

    a_r10_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_event |=> !resume_event);

    a_r10_event_state: assert property (@(posedge clk) disable iff (!rst_n)
        resume_event |-> (hcfs == 2'b01));
endmodule

bind usb_hc_state_ctrl hc_state_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wdata         (wdata),
    .frame_start   (frame_start),
    .resume_detect (resume_detect),
    .sw_reset      (sw_reset),
    .hcfs          (hcfs),
    .ble_active    (ble_active),
    .cle_active    (cle_active),
    .resume_event  (resume_event)
);

// File: tb/sim_usb_hc_state_ctrl.sv
`timescale 1ns/1ps
module sim_usb_hc_state_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       frame_start = 1'b0;
    logic       resume_detect = 1'b0;
    logic       sw_reset = 1'b0;
    logic [1:0] hcfs;
    logic       ble_active, cle_active, resume_event;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_state = 0;
    int m_sb = 0, m_sc = 0;
    int m_ab = 0, m_ac = 0;
    int m_ev = 0;

    always #4 clk = ~clk;

    usb_hc_state_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .frame_start(frame_start), .resume_detect(resume_detect),
        .sw_reset(sw_reset), .hcfs(hcfs), .ble_active(ble_active),
        .cle_active(cle_active), .resume_event(resume_event)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_sb = 0; m_sc = 0; m_ab = 0; m_ac = 0; m_ev = 0;
        end else if (sw_reset) begin
            m_state = 3; m_sb = 0; m_sc = 0; m_ab = 0; m_ac = 0; m_ev = 0;
        end else begin
            m_ev = 0;
            if (frame_start) begin m_ab = m_sb; m_ac = m_sc; end
            if (wr_en) begin
                m_state = int'(wdata[1:0]);
                m_sc = int'(wdata[2]);
                m_sb = int'(wdata[3]);
            end else if (m_state == 3 && resume_detect) begin
                m_state = 1; m_ev = 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1 R3 R4 R5 R6 R9 hcfs", int'(hcfs), m_state);
        check("R7 R8 ble_active", int'(ble_active), m_ab);
        check("R7 R8 cle_active", int'(cle_active), m_ac);
        check("R10 resume_event", int'(resume_event), m_ev);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wr_en = 0; frame_start = 0; resume_detect = 0; sw_reset = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R2: reset state
        check("R2 hcfs", int'(hcfs), 0);
        check("R2 ble", int'(ble_active), 0);
        check("R2 event", int'(resume_event), 0);
        step();
        rst_n = 1;
        step();
        // R5: resume in RESET ignored
        resume_detect = 1; step(); idle();
        check("R5 reset ignores resume", int'(hcfs), 0);
        // R3: write OPER with both enables, upper bits set
        wr_en = 1; wdata = 8'hFE; step(); idle();
        check("R3 state OPER", int'(hcfs), 2);
        check("R8 not yet active", int'(ble_active), 0);
        resume_detect = 1; step(); idle();
        check("R5 oper ignores resume", int'(hcfs), 2);
        frame_start = 1; step(); idle();
        check("R7 bulk active", int'(ble_active), 1);
        check("R7 ctrl active", int'(cle_active), 1);
        // R8: mid-frame clear has no effect
        wr_en = 1; wdata = 8'h02; step(); idle();
        check("R8 bulk held", int'(ble_active), 1);
        // R7: frame with same-cycle write sees pre-write value (0)
        frame_start = 1; wr_en = 1; wdata = 8'h0E; step(); idle();
        check("R7 pre-write bulk", int'(ble_active), 0);
        frame_start = 1; step(); idle();
        check("R7 next frame bulk", int'(ble_active), 1);
        check("R7 next frame ctrl", int'(cle_active), 1);
        // R4: sw reset beats write
        sw_reset = 1; wr_en = 1; wdata = 8'h0E; frame_start = 1; step(); idle();
        check("R4 suspend", int'(hcfs), 3);
        check("R4 enables cleared", int'(ble_active), 0);
        // R6 and R10: autonomous resume
        resume_detect = 1; step(); idle();
        check("R6 resume", int'(hcfs), 1);
        check("R10 pulse high", int'(resume_event), 1);
        step();
        check("R10 pulse low", int'(resume_event), 0);
        resume_detect = 1; step(); idle();
        check("R5 resume state ignores", int'(resume_event), 0);
        // R9: write wins over resume
        wr_en = 1; wdata = 8'h03; step(); idle();
        wr_en = 1; wdata = 8'h02; resume_detect = 1; step(); idle();
        check("R9 write wins", int'(hcfs), 2);
        check("R9 no event", int'(resume_event), 0);
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            wr_en = ($urandom_range(0, 3) == 0);
            wdata = 8'($urandom);
            frame_start = ($urandom_range(0, 4) == 0);
            resume_detect = ($urandom_range(0, 1) == 0);
            sw_reset = ($urandom_range(0, 15) == 0);
            step();
        end
        idle();
        step();
        finish_run();
    end
endmodule